// File: doc/BRIEF.md
# Write-Protected 16-Pin GPIO Port Controller

This block runs one 16-pin general-purpose I/O port from a small word-wide register bus. Each pin has its own routing bit. The bit either hands the pad to an on-chip peripheral (output value, output enable, and the returned input) or keeps the pad on a software-driven digital path. On the software path, a per-pin direction bit decides whether the pad is driven from an output latch or only sensed.

Software changes the output latch in one of two ways. It can write a whole word, or it can write a mask to one of three strobe offsets: one forces bits high, one forces them low, and one inverts them. Only the bits written as 1 are affected, so there is no read-modify-write race. The routing, direction and qualification registers form a protected set: a write to them lands only while the protection-enable input is high. The data path is never gated. Every pad input passes through a two-flop synchronizer before software or the peripheral sees it.

Top module: `gpio_port_ctrl`

## Requirements
- R1: After reset, the routing, direction, qualification and output latch registers all read 0. `pin_oe` is 0, `pin_out` is 0 and `per_in` is 0.
- R2: A pin whose routing bit (offset 0) is 1 takes `pin_out`/`pin_oe` from `per_out`/`per_oe`, and `per_in` carries its synchronized input. A pin whose routing bit is 0 has `per_in` held at 0.
- R3: A pin whose routing bit is 0 drives `pin_out` from its output latch. Its `pin_oe` equals its direction bit (offset 1): 1 = output, 0 = input.
- R4: Writes to offsets 0, 1 and 2 (routing, direction, qualification) update the register only while `prot_en` is 1. With `prot_en` at 0 they are dropped. These offsets read back their stored value.
- R5: A write to offset 4 loads the whole output latch from the write data, whatever the level of `prot_en`.
- R6: A write to offset 5 sets each latch bit whose data bit is 1 and leaves the other bits unchanged.
- R7: A write to offset 6 clears each latch bit whose data bit is 1 and leaves the other bits unchanged. Inside the latch, a clear mask wins over a set mask, and a set mask wins over a toggle mask.
- R8: A write to offset 7 inverts each latch bit whose data bit is 1. A write of all zeros leaves the latch unchanged.
- R9: A write to offset 3 changes no register. Reads of offsets 3, 5, 6 and 7 return 0.
- R10: A read of offset 4 returns, per pin, the latch bit when the direction bit is 1 and the synchronized pad input when it is 0. A pad change becomes visible after exactly two rising clock edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| prot_en | input | 1 | Opens the protected configuration registers for writing |
| bus_addr | input | 3 | Register word offset |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr` (combinational) |
| pin_out | output | 16 | Pad output values |
| pin_oe | output | 16 | Pad output enables |
| pin_in | input | 16 | Pad input values (asynchronous) |
| per_out | input | 16 | Peripheral output values |
| per_oe | input | 16 | Peripheral output enables |
| per_in | output | 16 | Synchronized pad inputs returned to the peripheral |

## Verification
Wrong internal state here shows up at the ports almost at once. A latch bit that a strobe updates wrongly appears on `pin_out` one edge after the write. A configuration write that slips past the protection gate flips `pin_oe`, or moves a pin to peripheral routing, on the next cycle. A synchronizer that is one stage short or long moves the point where the data read changes by one cycle, so the bench reads both one and two edges after a pad change. Strobe reads and the reserved offset are read back as zero, and the configuration words are read again after writes that must not touch them.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

    localparam int PINS   = 16;
    localparam int ADDR_W = 3;
    localparam int SYNC_STAGES = 2;

    typedef logic [PINS-1:0] pinvec_t;

    typedef enum logic [ADDR_W-1:0] {
        OFF_ROUTE = 3'd0,
        OFF_DIR   = 3'd1,
        OFF_QUAL  = 3'd2,
        OFF_RSVD  = 3'd3,
        OFF_DATA  = 3'd4,
        OFF_SET   = 3'd5,
        OFF_CLR   = 3'd6,
        OFF_TGL   = 3'd7
    } reg_off_e;

    typedef struct packed {
        pinvec_t route;  // 1 = peripheral owns pin
        pinvec_t dir;    // 1 = output
        pinvec_t qual;   // qualification setting, stored only
    } port_cfg_t;

    typedef struct packed {
        logic    load;
        pinvec_t load_val;
        pinvec_t set_m;
        pinvec_t clr_m;
        pinvec_t tgl_m;
    } latch_cmd_t;

    // Priority: clear over set over toggle over word load.
    function automatic pinvec_t next_latch(pinvec_t cur, latch_cmd_t c);
        pinvec_t v;
        v = c.load ? c.load_val : cur;
        v = v ^ c.tgl_m;
        v = v | c.set_m;
        v = v & ~c.clr_m;
        return v;
    endfunction

    function automatic latch_cmd_t decode_latch(logic we, reg_off_e off, pinvec_t d);
        latch_cmd_t c;
        c          = '0;
        c.load     = we && (off == OFF_DATA);
        c.load_val = d;
        if (we && off == OFF_SET) c.set_m = d;
        if (we && off == OFF_CLR) c.clr_m = d;
        if (we && off == OFF_TGL) c.tgl_m = d;
        return c;
    endfunction

endpackage

// File: rtl/gpio_cfg_bank.sv
module gpio_cfg_bank
    import gpio_port_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      prot_en,
    input  logic      wr_en,
    input  reg_off_e  wr_off,
    input  pinvec_t   wr_data,
    output port_cfg_t cfg
);

    logic open_wr;
    assign open_wr = wr_en && prot_en;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= '0;
        end else if (open_wr) begin
            case (wr_off)
                OFF_ROUTE: cfg.route <= wr_data;
                OFF_DIR:   cfg.dir   <= wr_data;
                OFF_QUAL:  cfg.qual  <= wr_data;
                default: ;
            endcase
        end
    end

    // R4: locked bank never changes
    p_locked_cfg_r4: assert property (@(posedge clk) disable iff (rst)
        !prot_en |=> $stable(cfg))
        else $error("protected configuration changed while locked");

    // R9: reserved offset write leaves the bank alone
    p_rsvd_nowrite_r9: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_off == OFF_RSVD) |=> $stable(cfg))
        else $error("reserved offset write altered configuration");

endmodule

// File: rtl/gpio_out_latch.sv
module gpio_out_latch
    import gpio_port_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  latch_cmd_t cmd,
    output pinvec_t    latch_q
);

    always_ff @(posedge clk) begin
        if (rst) latch_q <= '0;
        else     latch_q <= next_latch(latch_q, cmd);
    end

    // R6: set bits end high unless also cleared
    p_set_hi_r6: assert property (@(posedge clk) disable iff (rst)
        (cmd.set_m != '0) |=> ((latch_q & ($past(cmd.set_m) & ~$past(cmd.clr_m)))
                               == ($past(cmd.set_m) & ~$past(cmd.clr_m))))
        else $error("set strobe did not raise latch bits");

    // R7: cleared bits always end low (clear has top priority)
    p_clr_lo_r7: assert property (@(posedge clk) disable iff (rst)
        (cmd.clr_m != '0) |=> ((latch_q & $past(cmd.clr_m)) == '0))
        else $error("clear strobe did not lower latch bits");

    // R8: toggle alone inverts exactly the masked bits
    p_tgl_flip_r8: assert property (@(posedge clk) disable iff (rst)
        (!cmd.load && cmd.set_m == '0 && cmd.clr_m == '0 && cmd.tgl_m != '0)
        |=> (latch_q == ($past(latch_q) ^ $past(cmd.tgl_m))))
        else $error("toggle strobe result wrong");

    // R8: no command, no change
    p_idle_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (cmd == '0) |=> $stable(latch_q))
        else $error("latch moved without a command");

endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync
    import gpio_port_pkg::*;
#(
    parameter int STAGES = SYNC_STAGES
)(
    input  logic    clk,
    input  logic    rst,
    input  pinvec_t din,
    output pinvec_t dout
);

    pinvec_t chain [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < STAGES; k++) chain[k] <= '0;
        end else begin
            chain[0] <= din;
            for (int k = 1; k < STAGES; k++) chain[k] <= chain[k-1];
        end
    end

    assign dout = chain[STAGES-1];

endmodule

// File: rtl/gpio_pin_mux.sv
module gpio_pin_mux
    import gpio_port_pkg::*;
(
    input  port_cfg_t cfg,
    input  pinvec_t   latch_q,
    input  pinvec_t   sync_in,
    input  pinvec_t   per_out,
    input  pinvec_t   per_oe,
    output pinvec_t   pin_out,
    output pinvec_t   pin_oe,
    output pinvec_t   per_in,
    output pinvec_t   sw_view
);

    for (genvar i = 0; i < PINS; i++) begin : g_pin
        always_comb begin
            if (cfg.route[i]) begin
                pin_out[i] = per_out[i];
                pin_oe[i]  = per_oe[i];
                per_in[i]  = sync_in[i];
            end else begin
                pin_out[i] = latch_q[i];
                pin_oe[i]  = cfg.dir[i];
                per_in[i]  = 1'b0;
            end
            sw_view[i] = cfg.dir[i] ? latch_q[i] : sync_in[i];
        end
    end

endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
    import gpio_port_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                prot_en,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_we,
    input  logic [PINS-1:0]     bus_wdata,
    output logic [PINS-1:0]     bus_rdata,
    output logic [PINS-1:0]     pin_out,
    output logic [PINS-1:0]     pin_oe,
    input  logic [PINS-1:0]     pin_in,
    input  logic [PINS-1:0]     per_out,
    input  logic [PINS-1:0]     per_oe,
    output logic [PINS-1:0]     per_in
);

    reg_off_e   off;
    port_cfg_t  cfg;
    latch_cmd_t cmd;
    pinvec_t    latch_q;
    pinvec_t    sync_in;
    pinvec_t    sw_view;

    assign off = reg_off_e'(bus_addr);
    assign cmd = decode_latch(bus_we, off, bus_wdata);

    gpio_cfg_bank u_cfg (
        .clk     (clk),
        .rst     (rst),
        .prot_en (prot_en),
        .wr_en   (bus_we),
        .wr_off  (off),
        .wr_data (bus_wdata),
        .cfg     (cfg)
    );

    gpio_out_latch u_latch (
        .clk     (clk),
        .rst     (rst),
        .cmd     (cmd),
        .latch_q (latch_q)
    );

    gpio_in_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (pin_in),
        .dout (sync_in)
    );

    gpio_pin_mux u_mux (
        .cfg     (cfg),
        .latch_q (latch_q),
        .sync_in (sync_in),
        .per_out (per_out),
        .per_oe  (per_oe),
        .pin_out (pin_out),
        .pin_oe  (pin_oe),
        .per_in  (per_in),
        .sw_view (sw_view)
    );

    always_comb begin
        case (off)
            OFF_ROUTE: bus_rdata = cfg.route;
            OFF_DIR:   bus_rdata = cfg.dir;
            OFF_QUAL:  bus_rdata = cfg.qual;
            OFF_DATA:  bus_rdata = sw_view;
            default:   bus_rdata = '0;
        endcase
    end

    // R2: peripheral input only reaches routed pins
    p_per_in_mask_r2: assert property (@(posedge clk) disable iff (rst)
        (per_in & ~cfg.route) == '0)
        else $error("per_in active on a software-owned pin");

    // R3: software input pins never drive
    p_in_hiz_r3: assert property (@(posedge clk) disable iff (rst)
        (pin_oe & ~cfg.route & ~cfg.dir) == '0)
        else $error("input pin is driving");

    // R1: first cycle after reset leaves all pads undriven
    p_reset_quiet_r1: assert property (@(posedge clk)
        rst |=> (pin_oe == '0 && per_in == '0))
        else $error("pads driven right after reset");

endmodule

// File: tb/tb_gpio_port_ctrl.sv
module tb_gpio_port_ctrl;

    localparam int CLK_PERIOD = 10;

    localparam int SRC_RD  = 0;
    localparam int SRC_OUT = 1;
    localparam int SRC_OE  = 2;
    localparam int SRC_PIN = 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        prot_en = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [15:0] pin_out, pin_oe, per_in;
    logic [15:0] pin_in = '0;
    logic [15:0] per_out = '0;
    logic [15:0] per_oe = '0;

    gpio_port_ctrl dut (
        .clk(clk), .rst(rst), .prot_en(prot_en),
        .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .pin_out(pin_out), .pin_oe(pin_oe),
        .pin_in(pin_in), .per_out(per_out), .per_oe(per_oe), .per_in(per_in)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct {
        int          req;
        int          src;
        logic [15:0] exp;
    } item_t;

    item_t q[$];
    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    // monitor: compares queued expectations just after each falling edge
    always @(negedge clk) begin
        #1;
        while (q.size() > 0) begin
            item_t it;
            logic [15:0] act;
            it = q.pop_front();
            case (it.src)
                SRC_RD:  act = bus_rdata;
                SRC_OUT: act = pin_out;
                SRC_OE:  act = pin_oe;
                default: act = per_in;
            endcase
            n_chk++;
            if (act !== it.exp) begin
                n_fail++;
                $display("FAIL R%0d src=%0d actual=%h expected=%h", it.req, it.src, act, it.exp);
            end
        end
    end

    task automatic push(int req, int src, logic [15:0] exp);
        item_t it;
        it.req = req; it.src = src; it.exp = exp;
        q.push_back(it);
    endtask

    task automatic expect_rd(int req, logic [2:0] a, logic [15:0] exp);
        @(negedge clk);
        bus_addr = a;
        push(req, SRC_RD, exp);
    endtask

    task automatic expect_port(int req, int src, logic [15:0] exp);
        @(negedge clk);
        push(req, src, exp);
    endtask

    task automatic wr(logic [2:0] a, logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_we = 1'b1; bus_wdata = d;
        @(posedge clk);
        #1 bus_we = 1'b0;
    endtask

    task automatic set_pins(logic [15:0] v);
        @(negedge clk);
        pin_in = v;
        repeat (2) @(posedge clk);
    endtask

    // watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [15:0] lat, dir, sel;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R1: reset state
        expect_rd(1, 3'd0, 16'h0000);
        expect_rd(1, 3'd1, 16'h0000);
        expect_rd(1, 3'd2, 16'h0000);
        expect_rd(1, 3'd4, 16'h0000);
        expect_port(1, SRC_OE, 16'h0000);
        expect_port(1, SRC_OUT, 16'h0000);
        expect_port(1, SRC_PIN, 16'h0000);

        // R4: locked writes are dropped
        wr(3'd0, 16'hFFFF);
        wr(3'd1, 16'hFFFF);
        expect_rd(4, 3'd0, 16'h0000);
        expect_rd(4, 3'd1, 16'h0000);

        // R4: unlocked writes land
        prot_en = 1'b1;
        wr(3'd1, 16'h00FF);
        wr(3'd2, 16'h1234);
        prot_en = 1'b0;
        dir = 16'h00FF; sel = 16'h0000;
        expect_rd(4, 3'd1, dir);
        expect_rd(4, 3'd2, 16'h1234);

        // R5 / R3: word load with protection closed
        wr(3'd4, 16'hA5C3); lat = 16'hA5C3;
        expect_port(5, SRC_OUT, lat);
        expect_port(3, SRC_OE, dir);

        // R10: mixed readback
        set_pins(16'h5A00);
        expect_rd(10, 3'd4, (lat & dir) | (16'h5A00 & ~dir));

        // R6: set strobe
        wr(3'd5, 16'h0F0F); lat = lat | 16'h0F0F;
        expect_port(6, SRC_OUT, lat);
        expect_rd(9, 3'd5, 16'h0000);

        // R7: clear strobe
        wr(3'd6, 16'h00F0); lat = lat & ~16'h00F0;
        expect_port(7, SRC_OUT, lat);

        // R8: toggle strobe, then all-zero toggle
        wr(3'd7, 16'hFFFF); lat = ~lat;
        expect_port(8, SRC_OUT, lat);
        wr(3'd7, 16'h0000);
        expect_port(8, SRC_OUT, lat);

        // R9: reserved offset
        wr(3'd3, 16'hFFFF);
        expect_rd(9, 3'd3, 16'h0000);
        expect_rd(9, 3'd0, 16'h0000);
        expect_rd(9, 3'd1, dir);
        expect_rd(9, 3'd2, 16'h1234);
        expect_rd(9, 3'd6, 16'h0000);
        expect_rd(9, 3'd7, 16'h0000);
        expect_port(9, SRC_OUT, lat);

        // R2: peripheral routing on upper nibble
        prot_en = 1'b1;
        wr(3'd0, 16'hF000); sel = 16'hF000;
        prot_en = 1'b0;
        per_out = 16'hAAAA; per_oe = 16'h5555;
        expect_port(2, SRC_OUT, (per_out & sel) | (lat & ~sel));
        expect_port(2, SRC_OE,  (per_oe & sel) | (dir & ~sel));
        expect_port(2, SRC_PIN, 16'h5A00 & sel);
        expect_rd(4, 3'd0, sel);

        // R10: two-edge input latency
        @(negedge clk);
        bus_addr = 3'd4;
        pin_in = 16'hFF00;
        expect_rd(10, 3'd4, (lat & dir) | (16'h5A00 & ~dir));
        expect_rd(10, 3'd4, (lat & dir) | (16'hFF00 & ~dir));
        expect_port(2, SRC_PIN, 16'hFF00 & sel);

        @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule